// File: doc/BRIEF.md
# Cross-Cluster Register Scoreboard

This block tracks which of a processor cluster's 32 registers hold usable values and decides, each cycle, how many of the two in-order instruction slots may issue. Operands are read only from the cluster's own register file. Any other cluster may deposit a result into this file through a single network write port. Software prepares a register for such a deposit with an EMPTY operation, which marks the register invalid. Any later instruction that reads the register then stalls until the network write arrives and re-validates it. Remote writes are never invalidated automatically at issue.

Local producers are tracked in the usual way. An instruction whose result lands in a local register marks that register invalid when it issues. The local writeback port marks it valid again. Both writers share one storage write port. The issue interface is valid/ready per slot, and ready means the instruction issues on that edge. Slot 1 is only accepted together with slot 0. The network port is valid/ready: `nw_ready` falls whenever a local writeback owns the write port, and the sender must then hold its request. The local writeback port has no back-pressure.

Top module: `xcl_scoreboard`

## Requirements
- R1: After reset every register is valid and reads as zero.
- R2: Slot 0 asserts ready exactly when it is valid, each source it uses is valid, and, for a non-EMPTY instruction with a local destination, that destination is valid. A source whose use flag is low is ignored.
- R3: An issued EMPTY, which is `is_empty` = 1, makes its `dst` register invalid from the next cycle. It issues regardless of register state, and its source and `dst_local` fields are ignored.
- R4: An accepted network write (`nw_valid` and `nw_ready` both high) stores `nw_data` into `nw_reg` and makes it valid from the next cycle.
- R5: `nw_ready` is low in any cycle in which `wb_valid` is high. A network request offered in such a cycle changes nothing.
- R6: A local writeback stores `wb_data` into `wb_reg` and makes it valid from the next cycle.
- R7: An issued non-EMPTY instruction with `dst_local` = 1 makes `dst` invalid from the next cycle. With `dst_local` = 0 it leaves every valid bit unchanged.
- R8: Slot 1 asserts ready only when slot 0 issues in the same cycle and slot 1 passes the R2 checks. It must also not read, or locally write, a register that slot 0 invalidates in that cycle.
- R9: When an EMPTY and an accepted network write name the same register in one cycle, the register ends valid and holds the network data.
- R10: When an EMPTY and a local writeback name the same register in one cycle, the register ends invalid.
- R11: The operand outputs `op<s>_a` and `op<s>_b` carry the current contents of the register named by the matching source field, as stored at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i0_valid | input | 1 | Slot 0 instruction present |
| i0_ready | output | 1 | Slot 0 issues this cycle |
| i0_is_empty | input | 1 | Slot 0 is an EMPTY operation |
| i0_use_a | input | 1 | Slot 0 reads source A |
| i0_src_a | input | 5 | Slot 0 source A index |
| i0_use_b | input | 1 | Slot 0 reads source B |
| i0_src_b | input | 5 | Slot 0 source B index |
| i0_dst_local | input | 1 | Slot 0 result targets this cluster |
| i0_dst | input | 5 | Slot 0 destination index |
| i1_valid | input | 1 | Slot 1 instruction present |
| i1_ready | output | 1 | Slot 1 issues this cycle |
| i1_is_empty | input | 1 | Slot 1 is an EMPTY operation |
| i1_use_a | input | 1 | Slot 1 reads source A |
| i1_src_a | input | 5 | Slot 1 source A index |
| i1_use_b | input | 1 | Slot 1 reads source B |
| i1_src_b | input | 5 | Slot 1 source B index |
| i1_dst_local | input | 1 | Slot 1 result targets this cluster |
| i1_dst | input | 5 | Slot 1 destination index |
| op0_a | output | 32 | Slot 0 source A data |
| op0_b | output | 32 | Slot 0 source B data |
| op1_a | output | 32 | Slot 1 source A data |
| op1_b | output | 32 | Slot 1 source B data |
| wb_valid | input | 1 | Local writeback strobe |
| wb_reg | input | 5 | Local writeback register |
| wb_data | input | 32 | Local writeback value |
| nw_valid | input | 1 | Network write request |
| nw_ready | output | 1 | Network write accepted |
| nw_reg | input | 5 | Network write register |
| nw_data | input | 32 | Network write value |

## Verification
A valid bit that is wrongly set or cleared has no port of its own. It shows up at the next edge as a ready that is high or low when it should not be, on any instruction that names the register. Every register is therefore probed with a read that has a remote destination, which changes no state, one cycle after each event that should move its bit. Wrong storage appears on the operand outputs in that same probe cycle. A wrong pair-hazard decision appears combinationally on `i1_ready` in the very cycle the pair is offered.

// File: rtl/xcl_pkg.sv
package xcl_pkg;

  // Owner of the single storage write port in a cycle.
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_LOCAL = 2'd1,
    WR_NET   = 2'd2
  } wr_src_e;

  localparam int unsigned SLOTS = 2;
  localparam int unsigned RD_PER_SLOT = 2;

endpackage

// File: rtl/xcl_regfile.sv
module xcl_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [DW-1:0]         wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Reads see the value stored at the last edge; no same-cycle bypass.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/xcl_valid_bits.sv
module xcl_valid_bits #(
  parameter int NREG = 32,
  parameter int NCLR = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wb_set,
  input  logic [AW-1:0]          wb_idx,
  input  logic                   net_set,
  input  logic [AW-1:0]          net_idx,
  input  logic [NCLR-1:0]        clr_en,
  input  logic [NCLR-1:0][AW-1:0] clr_idx,
  output logic [NREG-1:0]        vbits
);

  // Precedence per bit: network set > any clear > local writeback set.
  for (genvar r = 0; r < NREG; r++) begin : g_bit
    logic wb_hit, net_hit, clr_hit;

    always_comb begin
      wb_hit  = wb_set  && (wb_idx  == AW'(r));
      net_hit = net_set && (net_idx == AW'(r));
      clr_hit = 1'b0;
      for (int c = 0; c < NCLR; c++) begin
        if (clr_en[c] && (clr_idx[c] == AW'(r))) clr_hit = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) vbits[r] <= 1'b1;
      else        vbits[r] <= ((vbits[r] | wb_hit) & ~clr_hit) | net_hit;
    end
  end

endmodule

// File: rtl/xcl_issue_check.sv
module xcl_issue_check #(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int NS  = xcl_pkg::SLOTS
) (
  input  logic [NREG-1:0]       vbits,
  input  logic [NS-1:0]         s_valid,
  input  logic [NS-1:0]         s_empty,
  input  logic [NS-1:0]         s_use_a,
  input  logic [NS-1:0]         s_use_b,
  input  logic [NS-1:0]         s_dst_local,
  input  logic [NS-1:0][AW-1:0] s_src_a,
  input  logic [NS-1:0][AW-1:0] s_src_b,
  input  logic [NS-1:0][AW-1:0] s_dst,
  output logic [NS-1:0]         go,
  output logic [NS-1:0]         clr_en,
  output logic [NS-1:0][AW-1:0] clr_idx
);

  logic [NS-1:0] need_a, need_b, wr_loc, ok, pend;

  // Per-slot check against the registered valid bits.
  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign need_a[s] = s_use_a[s] & ~s_empty[s];
    assign need_b[s] = s_use_b[s] & ~s_empty[s];
    assign wr_loc[s] = s_dst_local[s] & ~s_empty[s];
    assign pend[s]   = s_empty[s] | wr_loc[s];
    assign ok[s]     = s_valid[s]
                     & (~need_a[s] | vbits[s_src_a[s]])
                     & (~need_b[s] | vbits[s_src_b[s]])
                     & (~wr_loc[s] | vbits[s_dst[s]]);
    assign clr_en[s]  = go[s] & pend[s];
    assign clr_idx[s] = s_dst[s];
  end

  // Intra-pair hazard: slot 1 against what slot 0 invalidates now.
  logic haz1;
  always_comb begin
    haz1 = pend[0] & ((need_a[1] & (s_src_a[1] == s_dst[0]))
                    | (need_b[1] & (s_src_b[1] == s_dst[0]))
                    | (wr_loc[1] & (s_dst[1]   == s_dst[0])));
    go[0] = ok[0];
    go[1] = ok[0] & ok[1] & ~haz1;
  end

endmodule

// File: rtl/xcl_scoreboard.sv
module xcl_scoreboard #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i0_valid,
  output logic          i0_ready,
  input  logic          i0_is_empty,
  input  logic          i0_use_a,
  input  logic [AW-1:0] i0_src_a,
  input  logic          i0_use_b,
  input  logic [AW-1:0] i0_src_b,
  input  logic          i0_dst_local,
  input  logic [AW-1:0] i0_dst,
  input  logic          i1_valid,
  output logic          i1_ready,
  input  logic          i1_is_empty,
  input  logic          i1_use_a,
  input  logic [AW-1:0] i1_src_a,
  input  logic          i1_use_b,
  input  logic [AW-1:0] i1_src_b,
  input  logic          i1_dst_local,
  input  logic [AW-1:0] i1_dst,
  output logic [DW-1:0] op0_a,
  output logic [DW-1:0] op0_b,
  output logic [DW-1:0] op1_a,
  output logic [DW-1:0] op1_b,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_reg,
  input  logic [DW-1:0] wb_data,
  input  logic          nw_valid,
  output logic          nw_ready,
  input  logic [AW-1:0] nw_reg,
  input  logic [DW-1:0] nw_data
);
  import xcl_pkg::*;

  localparam int NS  = SLOTS;
  localparam int NRD = SLOTS * RD_PER_SLOT;

  logic [NREG-1:0] vbits;

  // Write-port ownership: local writeback first, network waits.
  wr_src_e       wsel;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  always_comb begin
    if (wb_valid)      wsel = WR_LOCAL;
    else if (nw_valid) wsel = WR_NET;
    else               wsel = WR_NONE;
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    case (wsel)
      WR_LOCAL: begin we = 1'b1; waddr = wb_reg; wdata = wb_data; end
      WR_NET:   begin we = 1'b1; waddr = nw_reg; wdata = nw_data; end
      default:  ;
    endcase
  end

  assign nw_ready = ~wb_valid;

  // Slot bundles.
  logic [NS-1:0]         s_valid, s_empty, s_use_a, s_use_b, s_dst_local;
  logic [NS-1:0][AW-1:0] s_src_a, s_src_b, s_dst;
  logic [NS-1:0]         go, clr_en;
  logic [NS-1:0][AW-1:0] clr_idx;

  assign s_valid     = {i1_valid,     i0_valid};
  assign s_empty     = {i1_is_empty,  i0_is_empty};
  assign s_use_a     = {i1_use_a,     i0_use_a};
  assign s_use_b     = {i1_use_b,     i0_use_b};
  assign s_dst_local = {i1_dst_local, i0_dst_local};
  assign s_src_a     = {i1_src_a,     i0_src_a};
  assign s_src_b     = {i1_src_b,     i0_src_b};
  assign s_dst       = {i1_dst,       i0_dst};

  assign i0_ready = go[0];
  assign i1_ready = go[1];

  xcl_issue_check #(.NREG(NREG)) u_issue (
    .vbits       (vbits),
    .s_valid     (s_valid),
    .s_empty     (s_empty),
    .s_use_a     (s_use_a),
    .s_use_b     (s_use_b),
    .s_dst_local (s_dst_local),
    .s_src_a     (s_src_a),
    .s_src_b     (s_src_b),
    .s_dst       (s_dst),
    .go          (go),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx)
  );

  xcl_valid_bits #(.NREG(NREG), .NCLR(NS)) u_vbits (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_set  (wb_valid),
    .wb_idx  (wb_reg),
    .net_set (nw_valid & nw_ready),
    .net_idx (nw_reg),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .vbits   (vbits)
  );

  logic [NRD-1:0][AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] rdata;

  assign raddr = {i1_src_b, i1_src_a, i0_src_b, i0_src_a};
  assign op0_a = rdata[0];
  assign op0_b = rdata[1];
  assign op1_a = rdata[2];
  assign op1_b = rdata[3];

  xcl_regfile #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

endmodule

// File: rtl/xcl_scoreboard_chk.sv
module xcl_scoreboard_chk #(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            i0_valid,
  input logic            i0_ready,
  input logic            i0_is_empty,
  input logic            i0_use_a,
  input logic [AW-1:0]   i0_src_a,
  input logic [AW-1:0]   i0_dst,
  input logic            i1_ready,
  input logic            wb_valid,
  input logic            nw_valid,
  input logic            nw_ready,
  input logic [AW-1:0]   nw_reg,
  input logic [NREG-1:0] vbits
);

  a_r2_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    i0_ready && i0_use_a && !i0_is_empty |-> vbits[i0_src_a]);

  a_r2_ready_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    i0_ready |-> i0_valid);

  a_r3_empty_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    i0_ready && i0_is_empty && !(nw_valid && nw_ready && nw_reg == i0_dst)
    |=> !vbits[$past(i0_dst)]);

  // R4 and R9: an accepted network write always leaves its register valid.
  a_r4_net_validates: assert property (@(posedge clk) disable iff (!rst_n)
    nw_valid && nw_ready |=> vbits[$past(nw_reg)]);

  a_r5_port_owned_by_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !nw_ready);

  a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    i1_ready |-> i0_ready);

endmodule

bind xcl_scoreboard xcl_scoreboard_chk #(.NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .i0_valid    (i0_valid),
  .i0_ready    (i0_ready),
  .i0_is_empty (i0_is_empty),
  .i0_use_a    (i0_use_a),
  .i0_src_a    (i0_src_a),
  .i0_dst      (i0_dst),
  .i1_ready    (i1_ready),
  .wb_valid    (wb_valid),
  .nw_valid    (nw_valid),
  .nw_ready    (nw_ready),
  .nw_reg      (nw_reg),
  .vbits       (vbits)
);

// File: tb/test_xcl_scoreboard.sv
`timescale 1ns/1ps
module test_xcl_scoreboard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        i0_valid, i0_ready, i0_is_empty, i0_use_a, i0_use_b, i0_dst_local;
  logic [4:0]  i0_src_a, i0_src_b, i0_dst;
  logic        i1_valid, i1_ready, i1_is_empty, i1_use_a, i1_use_b, i1_dst_local;
  logic [4:0]  i1_src_a, i1_src_b, i1_dst;
  logic [31:0] op0_a, op0_b, op1_a, op1_b;
  logic        wb_valid, nw_valid, nw_ready;
  logic [4:0]  wb_reg, nw_reg;
  logic [31:0] wb_data, nw_data;

  xcl_scoreboard i_xcl_scoreboard (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_val [32];

  function automatic logic [31:0] pat(input int r, input int k);
    return 32'(r) * 32'h0100_0193 + 32'(k) * 32'h0001_0007 + 32'h0000_A5A5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    i0_valid = 0; i0_is_empty = 0; i0_use_a = 0; i0_use_b = 0; i0_dst_local = 0;
    i0_src_a = 0; i0_src_b = 0; i0_dst = 0;
    i1_valid = 0; i1_is_empty = 0; i1_use_a = 0; i1_use_b = 0; i1_dst_local = 0;
    i1_src_a = 0; i1_src_b = 0; i1_dst = 0;
    wb_valid = 0; wb_reg = 0; wb_data = 0;
    nw_valid = 0; nw_reg = 0; nw_data = 0;
  endtask

  // Read r in slot 0 with a remote destination: no state change.
  task automatic probe(input int r, input logic rdy, input string req);
    i0_valid = 1; i0_use_a = 1; i0_src_a = 5'(r);
    #1;
    chk(req, 32'(i0_ready), 32'(rdy));
    if (rdy) chk(req, op0_a, exp_val[r]);
    @(negedge clk); idle();
  endtask

  task automatic net_write(input int r, input logic [31:0] d);
    nw_valid = 1; nw_reg = 5'(r); nw_data = d;
    @(negedge clk); idle();
    exp_val[r] = d;
  endtask

  task automatic local_wb(input int r, input logic [31:0] d);
    wb_valid = 1; wb_reg = 5'(r); wb_data = d;
    @(negedge clk); idle();
    exp_val[r] = d;
  endtask

  task automatic do_empty(input int r);
    i0_valid = 1; i0_is_empty = 1; i0_dst = 5'(r); i0_use_a = 1; i0_src_a = 5'(r);
    #1; chk("R3 empty issues unconditionally", 32'(i0_ready), 32'd1);
    @(negedge clk); idle();
  endtask

  task automatic local_op(input int r);
    i0_valid = 1; i0_dst_local = 1; i0_dst = 5'(r);
    #1; chk("R7 local-dest op issues", 32'(i0_ready), 32'd1);
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    for (int r = 0; r < 32; r++) exp_val[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int r = 0; r < 32; r++) probe(r, 1'b1, "R1 reset valid/zero");
    #1; chk("R5 nw_ready idle", 32'(nw_ready), 32'd1);

    // R3 / R4 sweep: EMPTY blocks, network write releases with data
    for (int r = 0; r < 32; r++) begin
      do_empty(r);
      probe(r, 1'b0, "R3 empty blocks reader");
      net_write(r, pat(r, 1));
      probe(r, 1'b1, "R4 network write validates");
    end

    // R2: unused source ignored, used source checked
    do_empty(5);
    i0_valid = 1; i0_use_a = 0; i0_src_a = 5; i0_use_b = 1; i0_src_b = 6;
    #1; chk("R2 unused src ignored", 32'(i0_ready), 32'd1);
    chk("R11 op0_b data", op0_b, exp_val[6]);
    i0_src_b = 5;
    #1; chk("R2 used src b invalid", 32'(i0_ready), 32'd0);
    @(negedge clk); idle();
    net_write(5, pat(5, 2));

    // R5: writeback blocks the network port
    wb_valid = 1; wb_reg = 20; wb_data = pat(20, 3);
    nw_valid = 1; nw_reg = 21; nw_data = pat(21, 3);
    #1; chk("R5 nw_ready low under wb", 32'(nw_ready), 32'd0);
    @(negedge clk); idle();
    exp_val[20] = pat(20, 3);
    probe(21, 1'b1, "R5 blocked request not written");
    probe(20, 1'b1, "R6 writeback stored");

    // R7: local destination tracking
    local_op(7);
    probe(7, 1'b0, "R7 local dest invalid after issue");
    i0_valid = 1; i0_dst_local = 1; i0_dst = 7;
    #1; chk("R2 WAW on pending dst stalls", 32'(i0_ready), 32'd0);
    @(negedge clk); idle();
    local_wb(7, pat(7, 4));
    probe(7, 1'b1, "R6 writeback releases");
    i0_valid = 1; i0_dst = 8;
    @(negedge clk); idle();
    probe(8, 1'b1, "R7 remote dest leaves bit");

    // R8: pair rules
    do_empty(3);
    i0_valid = 1; i0_use_a = 1; i0_src_a = 3; i1_valid = 1;
    #1; chk("R8 slot0 stalled", 32'(i0_ready), 32'd0);
    chk("R8 slot1 waits for slot0", 32'(i1_ready), 32'd0);
    @(negedge clk); idle();
    net_write(3, pat(3, 5));

    i0_valid = 1; i1_valid = 1;
    #1; chk("R8 independent pair dual issues", 32'(i1_ready), 32'd1);
    @(negedge clk); idle();

    i0_valid = 1; i0_dst_local = 1; i0_dst = 10; i1_valid = 1; i1_use_a = 1; i1_src_a = 10;
    #1; chk("R8 slot0 issues", 32'(i0_ready), 32'd1);
    chk("R8 RAW on slot0 dst", 32'(i1_ready), 32'd0);
    @(negedge clk); idle();
    local_wb(10, pat(10, 6));

    i0_valid = 1; i0_dst_local = 1; i0_dst = 10; i1_valid = 1; i1_use_b = 1; i1_src_b = 11;
    #1; chk("R8 unrelated slot1 issues", 32'(i1_ready), 32'd1);
    chk("R11 op1_b data", op1_b, exp_val[11]);
    @(negedge clk); idle();
    local_wb(10, pat(10, 7));

    i0_valid = 1; i0_is_empty = 1; i0_dst = 12; i1_valid = 1; i1_use_a = 1; i1_src_a = 12;
    #1; chk("R8 read after paired EMPTY", 32'(i1_ready), 32'd0);
    @(negedge clk); idle();
    probe(12, 1'b0, "R3 empty slot0 cleared");
    net_write(12, pat(12, 8));

    i0_valid = 1; i0_dst_local = 1; i0_dst = 13; i1_valid = 1; i1_dst_local = 1; i1_dst = 13;
    #1; chk("R8 WAW within pair", 32'(i1_ready), 32'd0);
    @(negedge clk); idle();
    local_wb(13, pat(13, 9));

    do_empty(15);
    i0_valid = 1; i1_valid = 1; i1_use_a = 1; i1_src_a = 15;
    #1; chk("R8 slot1 own source invalid", 32'(i1_ready), 32'd0);
    chk("R8 slot0 unaffected", 32'(i0_ready), 32'd1);
    @(negedge clk); idle();
    net_write(15, pat(15, 10));

    i0_valid = 1; i1_valid = 1; i1_is_empty = 1; i1_dst = 16;
    #1; chk("R8 slot1 EMPTY issues", 32'(i1_ready), 32'd1);
    @(negedge clk); idle();
    probe(16, 1'b0, "R3 slot1 EMPTY clears");
    net_write(16, pat(16, 11));
    i1_valid = 1; i1_use_a = 1; i1_src_a = 16; i0_valid = 1;
    #1; chk("R11 op1_a data", op1_a, exp_val[16]);
    @(negedge clk); idle();

    // R9: EMPTY and network write collide
    for (int r = 0; r < 32; r++) begin
      i0_valid = 1; i0_is_empty = 1; i0_dst = 5'(r);
      nw_valid = 1; nw_reg = 5'(r); nw_data = pat(r, 12);
      @(negedge clk); idle();
      exp_val[r] = pat(r, 12);
      probe(r, 1'b1, "R9 network write wins over EMPTY");
    end

    // R10: EMPTY and local writeback collide
    local_op(14);
    i0_valid = 1; i0_is_empty = 1; i0_dst = 14;
    wb_valid = 1; wb_reg = 14; wb_data = pat(14, 13);
    @(negedge clk); idle();
    exp_val[14] = pat(14, 13);
    probe(14, 1'b0, "R10 EMPTY beats writeback");
    net_write(14, pat(14, 14));
    probe(14, 1'b1, "R10 released by network");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule